// File: doc/BRIEF.md
# USB IN endpoint handshake and toggle controller

This block holds the control and status byte of one transmit (IN) endpoint of a USB device function and decides how the endpoint answers each IN token. Software reads and writes the byte through a simple write-enable port whose read data always shows the current contents. The protocol engine reports four kinds of event: an IN token arrived, the host acknowledged a sent packet, a transmit transfer finished correctly, and a bus reset. A software-forced reset is accepted on a separate input.

For every IN token the block returns a registered handshake choice: send data, NAK, STALL, or stay silent. With it comes the data PID to use, DATA0 or DATA1. When a transfer completes, the hardware sets a completion flag and moves the endpoint to NAK, so software has time to refill the buffer. The data toggle flips only on the host's acknowledgement. Software can still force the toggle to either value. An interrupt line follows the completion flag, gated by an enable input.

Top module: `usb_in_ep_ctrl`

## Requirements
- R1: After a synchronous reset, cpu_rdata is 0x00, and resp_vld and irq are 0.
- R2: Bits 7:4 of cpu_rdata always read 0. Writing ones to them changes nothing.
- R3: A CPU write with no hardware event in the same cycle loads bit 2 (toggle) and bits 1:0 (status) from cpu_wdata. The new value shows on cpu_rdata after that clock edge.
- R4: Bit 3 is the completion flag, and xfer_ok sets it. A CPU write with bit 3 at 0 clears it. A write with bit 3 at 1 leaves it unchanged. If xfer_ok and a clearing write fall in the same cycle, the flag ends up set.
- R5: xfer_ok forces the status bits 1:0 to 10 (NAK). This wins over a CPU write in the same cycle.
- R6: host_ack inverts the toggle bit, and this wins over a CPU write in the same cycle. When host_ack and xfer_ok arrive together, the toggle flips, the status becomes NAK and the flag is set, all on the same edge.
- R7: bus_reset or soft_reset clears bits 2:0 and leaves bit 3 as it was. This takes priority over every other update of bits 2:0.
- R8: An IN token makes resp_vld 1 for exactly the next cycle. resp then carries the status as it stood when the token arrived: 00 means no handshake, 01 STALL, 10 NAK and 11 send data. data_pid carries the toggle bit, where 0 is DATA0 and 1 is DATA1. Without a token, resp_vld is 0.
- R9: irq equals (bit 3 AND irq_en) as it stood one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr_en | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Current register contents |
| in_token | input | 1 | IN token received for this endpoint |
| host_ack | input | 1 | Host ACK received for a sent packet |
| xfer_ok | input | 1 | Transmit transfer completed correctly |
| bus_reset | input | 1 | Reset signalled on the USB |
| soft_reset | input | 1 | Software-forced USB reset |
| irq_en | input | 1 | Interrupt enable |
| resp_vld | output | 1 | Handshake choice valid |
| resp | output | 2 | Handshake choice: 0 none, 1 STALL, 2 NAK, 3 data |
| data_pid | output | 1 | Data PID to send: 0 DATA0, 1 DATA1 |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take reset to be held for at least two clock edges. They also take the event inputs to be 0 or 1, never X, at every sampled edge. For the NAK and toggle properties, they take a bus or software reset in the same cycle as the exception that overrides the hardware update. The bench drives every input right after a rising edge, starts with all strobes low, and holds reset for several cycles. It pairs events in a single cycle only where a requirement sets out the result of that pairing.

// File: rtl/usb_in_ep_pkg.sv
package usb_in_ep_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'b00,
    ST_STALL = 2'b01,
    ST_NAK   = 2'b10,
    ST_READY = 2'b11
  } ep_stat_e;

  typedef enum logic [1:0] {
    HS_NONE  = 2'b00,
    HS_STALL = 2'b01,
    HS_NAK   = 2'b10,
    HS_DATA  = 2'b11
  } hs_e;

  localparam int FLAG_POS = 3;
  localparam int TOG_POS  = 2;
  localparam int USED_W   = 4;
endpackage

// File: rtl/usb_in_ep_csr.sv
module usb_in_ep_csr
  import usb_in_ep_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             xfer_ok,
  input  logic             host_ack,
  input  logic             usb_rst,
  output logic             flag_q,
  output logic             tog_q,
  output ep_stat_e         stat_q
);
  // flag: hardware set beats software clear
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
    end else if (xfer_ok) begin
      flag_q <= 1'b1;
    end else if (wr_en && !wdata[FLAG_POS]) begin
      flag_q <= 1'b0;
    end
  end

  // toggle: bus reset > host ack > software write
  always_ff @(posedge clk) begin
    if (rst || usb_rst) begin
      tog_q <= 1'b0;
    end else if (host_ack) begin
      tog_q <= ~tog_q;
    end else if (wr_en) begin
      tog_q <= wdata[TOG_POS];
    end
  end

  // status: bus reset > completion > software write
  always_ff @(posedge clk) begin
    if (rst || usb_rst) begin
      stat_q <= ST_OFF;
    end else if (xfer_ok) begin
      stat_q <= ST_NAK;
    end else if (wr_en) begin
      stat_q <= ep_stat_e'(wdata[1:0]);
    end
  end
endmodule

// File: rtl/usb_in_ep_resp.sv
module usb_in_ep_resp
  import usb_in_ep_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     in_token,
  input  ep_stat_e stat,
  input  logic     tog,
  output logic     resp_vld,
  output hs_e      resp,
  output logic     data_pid
);
  hs_e pick;

  always_comb begin
    unique case (stat)
      ST_STALL: pick = HS_STALL;
      ST_NAK:   pick = HS_NAK;
      ST_READY: pick = HS_DATA;
      default:  pick = HS_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_vld <= 1'b0;
      resp     <= HS_NONE;
      data_pid <= 1'b0;
    end else begin
      resp_vld <= in_token;
      if (in_token) begin
        resp     <= pick;
        data_pid <= tog;
      end
    end
  end
endmodule

// File: rtl/usb_in_ep_ctrl.sv
module usb_in_ep_ctrl
  import usb_in_ep_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_wr_en,
  input  logic [REG_W-1:0] cpu_wdata,
  output logic [REG_W-1:0] cpu_rdata,
  input  logic             in_token,
  input  logic             host_ack,
  input  logic             xfer_ok,
  input  logic             bus_reset,
  input  logic             soft_reset,
  input  logic             irq_en,
  output logic             resp_vld,
  output logic [1:0]       resp,
  output logic             data_pid,
  output logic             irq
);
  localparam int PAD_W = REG_W - USED_W;

  logic     flag_q;
  logic     tog_q;
  ep_stat_e stat_q;
  hs_e      resp_e;
  logic     usb_rst;

  assign usb_rst = bus_reset | soft_reset;

  usb_in_ep_csr #(.REG_W(REG_W)) csr_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cpu_wr_en),
    .wdata    (cpu_wdata),
    .xfer_ok  (xfer_ok),
    .host_ack (host_ack),
    .usb_rst  (usb_rst),
    .flag_q   (flag_q),
    .tog_q    (tog_q),
    .stat_q   (stat_q)
  );

  usb_in_ep_resp resp_i (
    .clk      (clk),
    .rst      (rst),
    .in_token (in_token),
    .stat     (stat_q),
    .tog      (tog_q),
    .resp_vld (resp_vld),
    .resp     (resp_e),
    .data_pid (data_pid)
  );

  assign resp = resp_e;

  generate
    if (PAD_W > 0) begin : g_pad
      assign cpu_rdata = {{PAD_W{1'b0}}, flag_q, tog_q, stat_q};
    end else begin : g_nopad
      assign cpu_rdata = {flag_q, tog_q, stat_q};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= flag_q & irq_en;
  end
endmodule

// File: rtl/usb_in_ep_ctrl_chk.sv
module usb_in_ep_ctrl_chk #(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [REG_W-1:0] cpu_rdata,
  input logic             in_token,
  input logic             host_ack,
  input logic             xfer_ok,
  input logic             bus_reset,
  input logic             soft_reset,
  input logic             irq_en,
  input logic             resp_vld,
  input logic [1:0]       resp,
  input logic             data_pid,
  input logic             irq
);
  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_rdata[REG_W-1:4] == '0);

  // R4
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_ok |=> cpu_rdata[3]);

  // R5
  nak_on_done_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_ok && !bus_reset && !soft_reset) |=> cpu_rdata[1:0] == 2'b10);

  // R6
  toggle_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (host_ack && !bus_reset && !soft_reset) |=> cpu_rdata[2] != $past(cpu_rdata[2]));

  // R7
  usb_reset_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_reset || soft_reset) |=> (cpu_rdata[2:0] == 3'b000));

  // R7
  usb_reset_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_reset || soft_reset) && !xfer_ok |=> cpu_rdata[3] == $past(cpu_rdata[3]));

  // R8
  resp_match_chk: assert property (@(posedge clk) disable iff (rst)
    in_token |=> resp_vld && resp == $past(cpu_rdata[1:0]) && data_pid == $past(cpu_rdata[2]));

  // R8
  resp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_token |=> !resp_vld);

  // R9
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    irq == $past(cpu_rdata[3] && irq_en));
endmodule

bind usb_in_ep_ctrl usb_in_ep_ctrl_chk #(.REG_W(REG_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .cpu_rdata  (cpu_rdata),
  .in_token   (in_token),
  .host_ack   (host_ack),
  .xfer_ok    (xfer_ok),
  .bus_reset  (bus_reset),
  .soft_reset (soft_reset),
  .irq_en     (irq_en),
  .resp_vld   (resp_vld),
  .resp       (resp),
  .data_pid   (data_pid),
  .irq        (irq)
);

// File: tb/usb_in_ep_ctrl_tb.sv
module usb_in_ep_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_wr_en = 1'b0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] cpu_rdata;
  logic       in_token = 1'b0;
  logic       host_ack = 1'b0;
  logic       xfer_ok = 1'b0;
  logic       bus_reset = 1'b0;
  logic       soft_reset = 1'b0;
  logic       irq_en = 1'b0;
  logic       resp_vld;
  logic [1:0] resp;
  logic       data_pid;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  usb_in_ep_ctrl #(.REG_W(8)) dut_i (
    .clk(clk), .rst(rst), .cpu_wr_en(cpu_wr_en), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .in_token(in_token), .host_ack(host_ack),
    .xfer_ok(xfer_ok), .bus_reset(bus_reset), .soft_reset(soft_reset),
    .irq_en(irq_en), .resp_vld(resp_vld), .resp(resp), .data_pid(data_pid),
    .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    cpu_wr_en = 1'b0; in_token = 1'b0; host_ack = 1'b0;
    xfer_ok = 1'b0; bus_reset = 1'b0; soft_reset = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    cpu_wr_en = 1'b1; cpu_wdata = d;
    tick();
  endtask

  task automatic t_reset_state();
    check("R1 rdata", cpu_rdata, 8'h00);
    check("R1 resp_vld", {7'd0, resp_vld}, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_upper_bits();
    wr(8'hFF);
    check("R2 upper bits / R3 write / R4 write-one", cpu_rdata, 8'h07);
    wr(8'hF2);
    check("R3 load toggle and status", cpu_rdata, 8'h02);
  endtask

  task automatic t_responses();
    for (int s = 0; s < 4; s++) begin
      for (int t = 0; t < 2; t++) begin
        wr({5'd0, t[0], s[1:0]});
        in_token = 1'b1;
        tick();
        check("R8 resp_vld", {7'd0, resp_vld}, 8'h01);
        check("R8 resp code", {6'd0, resp}, {6'd0, s[1:0]});
        check("R8 data_pid", {7'd0, data_pid}, {7'd0, t[0]});
        tick();
        check("R8 idle", {7'd0, resp_vld}, 8'h00);
      end
    end
  endtask

  task automatic t_flag();
    wr(8'h03);
    irq_en = 1'b1;
    xfer_ok = 1'b1;
    tick();
    check("R4 R5 completion", cpu_rdata, 8'h0A);
    check("R9 irq lags", {7'd0, irq}, 8'h00);
    tick();
    check("R9 irq high", {7'd0, irq}, 8'h01);
    wr(8'h0B);
    check("R4 write one keeps flag", cpu_rdata, 8'h0B);
    wr(8'h03);
    check("R4 write zero clears", cpu_rdata, 8'h03);
    cpu_wr_en = 1'b1; cpu_wdata = 8'h03; xfer_ok = 1'b1;
    tick();
    check("R4 R5 hw beats sw", cpu_rdata, 8'h0A);
    irq_en = 1'b0;
    tick();
    check("R9 irq gated", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_toggle();
    wr(8'h03);
    host_ack = 1'b1;
    tick();
    check("R6 flip to 1", cpu_rdata, 8'h07);
    cpu_wr_en = 1'b1; cpu_wdata = 8'h07; host_ack = 1'b1;
    tick();
    check("R6 ack beats write", cpu_rdata, 8'h03);
    host_ack = 1'b1; xfer_ok = 1'b1;
    tick();
    check("R6 ack with completion", cpu_rdata, 8'h0E);
  endtask

  task automatic t_usb_reset();
    bus_reset = 1'b1;
    tick();
    check("R7 bus reset keeps flag", cpu_rdata, 8'h08);
    wr(8'h07);
    check("R3 reload", cpu_rdata, 8'h07);
    cpu_wr_en = 1'b1; cpu_wdata = 8'h03; soft_reset = 1'b1;
    tick();
    check("R7 soft reset beats write", cpu_rdata, 8'h00);
    bus_reset = 1'b1; xfer_ok = 1'b1; host_ack = 1'b1;
    tick();
    check("R7 reset beats events", cpu_rdata, 8'h08);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    t_reset_state();
    t_upper_bits();
    t_responses();
    t_flag();
    t_toggle();
    t_usb_reset();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule